// File: doc/BRIEF.md
# Dual-Output Set/Clear Interrupt Controller

This block gathers up to 32 level-sensitive interrupt lines into one shared raw level vector. From that vector it drives two request outputs, a normal request and a fast request. Each output has its own enable mask. An output is high whenever any raw line that its mask enables is high. Both outputs are combinational, so a source change reaches them in the same cycle, and a mask change reaches them one clock edge after the write.

Software programs the masks over a simple word-addressed register bus. To change a mask, it writes ones to a set address or to a clear address, so no read-modify-write is needed. A software latch, set and cleared through its own pair of addresses, is ORed into line 0 to give a software-triggered interrupt. Several instances can be cascaded by wiring one controller's normal request into a source line of another.

Top module: `setclr_intc`

## Requirements
- R1: `irqOut` is high exactly when some bit of (level AND normal mask) is 1, combinationally from `srcLines`.
- R2: `fiqOut` is high exactly when some bit of (level AND fast mask) is 1.
- R3: Reads return the following: word 0 gives level AND normal mask; word 1 and word 9 give the raw level; word 2 gives the normal mask; word 8 gives level AND fast mask; word 10 gives the fast mask.
- R4: A write to word 2 ORs the write data into the normal mask, and a write to word 10 ORs it into the fast mask. The change is visible from the next cycle.
- R5: A write to word 3 clears the normal-mask bits that are 1 in the data, and a write to word 11 does the same for the fast mask.
- R6: A write to word 4 with data bit 0 set sets the software latch. A write to word 5 with data bit 0 set clears it. Data bits 31..1 on these two words, and a zero bit 0, have no effect. Reading word 4 returns level bit 0.
- R7: Level bit 0 is the OR of `srcLines[0]` and the software latch. Level bit n for n>0 equals `srcLines[n]`.
- R8: Words 3, 5, 11 and every unmapped word read as 0. Writes to words 0, 1, 8 and 9 change no state.
- R9: Reset clears both masks and the software latch.
- R10: A write to one channel's set or clear word leaves the other channel's mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access strobe, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Word offset |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Combinational read data (0 when no read is selected) |
| srcLines | input | NUM_SRC | Level-sensitive interrupt sources |
| irqOut | output | 1 | Normal interrupt request |
| fiqOut | output | 1 | Fast interrupt request |

## Verification
The assertions assume that a bus write lasts exactly one cycle with `busSel` and `busWrite` both high. They also assume that `busWdata` and `busAddr` are stable over that cycle, because each post-write check compares the mask with the data sampled in the previous cycle. The bench drives every access between falling edges and drops `busSel` again before the next access. Sources change only at falling edges, so the combinational output checks always see settled levels.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int OFF_IRQ_STAT = 0;
  localparam int OFF_IRQ_RAW  = 1;
  localparam int OFF_IRQ_SET  = 2;
  localparam int OFF_IRQ_CLR  = 3;
  localparam int OFF_SOFT_SET = 4;
  localparam int OFF_SOFT_CLR = 5;
  localparam int OFF_FIQ_STAT = 8;
  localparam int OFF_FIQ_RAW  = 9;
  localparam int OFF_FIQ_SET  = 10;
  localparam int OFF_FIQ_CLR  = 11;

  localparam int NUM_CHAN = 2;  // 0 = normal, 1 = fast

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_STAT,
    RD_RAW,
    RD_MASK,
    RD_SOFT
  } rd_sel_e;

  typedef struct packed {
    logic [NUM_CHAN-1:0] enSet;
    logic [NUM_CHAN-1:0] enClr;
    logic                softSet;
    logic                softClr;
    logic                chan;
    rd_sel_e             rdSel;
  } intc_strobe_t;
endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output intc_strobe_t      stb
);
  logic wrEn;
  logic rdEn;

  assign wrEn = busSel & busWrite;
  assign rdEn = busSel & ~busWrite;

  always_comb begin
    stb       = '0;
    stb.rdSel = RD_ZERO;
    case (busAddr)
      ADDR_W'(OFF_IRQ_STAT): if (rdEn) stb.rdSel = RD_STAT;
      ADDR_W'(OFF_IRQ_RAW):  if (rdEn) stb.rdSel = RD_RAW;
      ADDR_W'(OFF_IRQ_SET): begin
        if (rdEn) stb.rdSel = RD_MASK;
        stb.enSet[0] = wrEn;
      end
      ADDR_W'(OFF_IRQ_CLR):  stb.enClr[0] = wrEn;
      ADDR_W'(OFF_SOFT_SET): begin
        if (rdEn) stb.rdSel = RD_SOFT;
        stb.softSet = wrEn;
      end
      ADDR_W'(OFF_SOFT_CLR): stb.softClr = wrEn;
      ADDR_W'(OFF_FIQ_STAT): begin
        stb.chan = 1'b1;
        if (rdEn) stb.rdSel = RD_STAT;
      end
      ADDR_W'(OFF_FIQ_RAW):  if (rdEn) stb.rdSel = RD_RAW;
      ADDR_W'(OFF_FIQ_SET): begin
        stb.chan = 1'b1;
        if (rdEn) stb.rdSel = RD_MASK;
        stb.enSet[1] = wrEn;
      end
      ADDR_W'(OFF_FIQ_CLR):  stb.enClr[1] = wrEn;
      default: ;
    endcase
  end
endmodule

// File: rtl/intc_mask_reg.sv
module intc_mask_reg #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             setStb,
  input  logic             clrStb,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] mask
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       mask <= '0;
    else if (setStb) mask <= mask | wdata;
    else if (clrStb) mask <= mask & ~wdata;
  end
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  intc_strobe_t       stb,
  input  logic [DATA_W-1:0]  busWdata,
  input  logic [NUM_SRC-1:0] srcLines,
  output logic [DATA_W-1:0]  busRdata,
  output logic               irqOut,
  output logic               fiqOut,
  output logic [NUM_SRC-1:0] irqMask,
  output logic [NUM_SRC-1:0] fiqMask,
  output logic               softLatch
);
  logic [NUM_SRC-1:0] level;
  logic [NUM_SRC-1:0] maskArr [NUM_CHAN];
  logic [NUM_SRC-1:0] selMask;

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    intc_mask_reg #(.WIDTH(NUM_SRC)) u_mask (
      .clk   (clk),
      .rstN  (rstN),
      .setStb(stb.enSet[c]),
      .clrStb(stb.enClr[c]),
      .wdata (busWdata[NUM_SRC-1:0]),
      .mask  (maskArr[c])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          softLatch <= 1'b0;
    else if (stb.softSet && busWdata[0]) softLatch <= 1'b1;
    else if (stb.softClr && busWdata[0]) softLatch <= 1'b0;
  end

  assign level   = srcLines | {{(NUM_SRC-1){1'b0}}, softLatch};
  assign irqMask = maskArr[0];
  assign fiqMask = maskArr[1];
  assign irqOut  = |(level & maskArr[0]);
  assign fiqOut  = |(level & maskArr[1]);
  assign selMask = stb.chan ? maskArr[1] : maskArr[0];

  always_comb begin
    case (stb.rdSel)
      RD_STAT: busRdata = DATA_W'(level & selMask);
      RD_RAW:  busRdata = DATA_W'(level);
      RD_MASK: busRdata = DATA_W'(selMask);
      RD_SOFT: busRdata = DATA_W'(level[0]);
      default: busRdata = '0;
    endcase
  end
endmodule

// File: rtl/setclr_intc.sv
module setclr_intc
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWrite,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [NUM_SRC-1:0] srcLines,
  output logic               irqOut,
  output logic               fiqOut
);
  intc_strobe_t       stb;
  logic [NUM_SRC-1:0] irqMask;
  logic [NUM_SRC-1:0] fiqMask;
  logic               softLatch;

  intc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busSel  (busSel),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .stb     (stb)
  );

  intc_datapath #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .busWdata (busWdata),
    .srcLines (srcLines),
    .busRdata (busRdata),
    .irqOut   (irqOut),
    .fiqOut   (fiqOut),
    .irqMask  (irqMask),
    .fiqMask  (fiqMask),
    .softLatch(softLatch)
  );
endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               busSel,
  input logic               busWrite,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [DATA_W-1:0]  busWdata,
  input logic [NUM_SRC-1:0] srcLines,
  input logic               irqOut,
  input logic               fiqOut,
  input logic [NUM_SRC-1:0] irqMask,
  input logic [NUM_SRC-1:0] fiqMask,
  input logic               softLatch
);
  logic wr;
  assign wr = busSel && busWrite;

  assert_irq_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wr && busAddr == ADDR_W'(2)) |=>
      ((irqMask & $past(busWdata[NUM_SRC-1:0])) == $past(busWdata[NUM_SRC-1:0])));

  assert_fiq_clr_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wr && busAddr == ADDR_W'(11)) |=>
      ((fiqMask & $past(busWdata[NUM_SRC-1:0])) == '0));

  assert_chan_isolated_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wr && (busAddr == ADDR_W'(2) || busAddr == ADDR_W'(3))) |=> $stable(fiqMask));

  assert_status_write_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wr && (busAddr == ADDR_W'(0) || busAddr == ADDR_W'(1) ||
            busAddr == ADDR_W'(8) || busAddr == ADDR_W'(9)))
      |=> ($stable(irqMask) && $stable(fiqMask) && $stable(softLatch)));

  assert_irq_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    ((((srcLines | NUM_SRC'(softLatch)) & irqMask) == '0) |-> !irqOut));

  assert_fiq_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((((srcLines | NUM_SRC'(softLatch)) & fiqMask) == '0) |-> !fiqOut));

  assert_soft_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wr && busAddr == ADDR_W'(4) && busWdata[0]) |=> softLatch);
endmodule

bind setclr_intc intc_checker #(
  .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
  .busAddr(busAddr), .busWdata(busWdata), .srcLines(srcLines),
  .irqOut(irqOut), .fiqOut(fiqOut), .irqMask(irqMask),
  .fiqMask(fiqMask), .softLatch(softLatch)
);

// File: tb/sim_setclr_intc.sv
module sim_setclr_intc;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] srcLines = '0;
  logic        irqOut;
  logic        fiqOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  setclr_intc u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .srcLines(srcLines), .irqOut(irqOut), .fiqOut(fiqOut)
  );

  // {req[3:0], src[31:0], wr, waddr[3:0], wdata[31:0], raddr[3:0], exp[31:0], eIrq, eFiq}
  localparam int NV = 23;
  localparam logic [110:0] VEC [NV] = '{
    {4'd3,  32'h0000_0000, 1'b0, 4'd0,  32'h0000_0000, 4'd1,  32'h0000_0000, 1'b0, 1'b0}, // R3 raw idle
    {4'd4,  32'h0000_0010, 1'b1, 4'd2,  32'h0000_0030, 4'd2,  32'h0000_0030, 1'b1, 1'b0}, // R4 irq set
    {4'd10, 32'h0000_0010, 1'b1, 4'd10, 32'h0000_0100, 4'd10, 32'h0000_0100, 1'b1, 1'b0}, // R10 fiq set
    {4'd2,  32'h0000_0110, 1'b0, 4'd0,  32'h0000_0000, 4'd8,  32'h0000_0100, 1'b1, 1'b1}, // R2 fiq status
    {4'd5,  32'h0000_0110, 1'b1, 4'd3,  32'h0000_0010, 4'd2,  32'h0000_0020, 1'b0, 1'b1}, // R5 irq clear
    {4'd1,  32'h0000_0110, 1'b0, 4'd0,  32'h0000_0000, 4'd0,  32'h0000_0000, 1'b0, 1'b1}, // R1 irq status
    {4'd6,  32'h0000_0000, 1'b1, 4'd4,  32'hFFFF_FFFE, 4'd4,  32'h0000_0000, 1'b0, 1'b0}, // R6 bit0 zero
    {4'd6,  32'h0000_0000, 1'b1, 4'd4,  32'h0000_0001, 4'd1,  32'h0000_0001, 1'b0, 1'b0}, // R6 soft set
    {4'd7,  32'h0000_0000, 1'b1, 4'd2,  32'h0000_0001, 4'd0,  32'h0000_0001, 1'b1, 1'b0}, // R7 soft to irq
    {4'd6,  32'h0000_0000, 1'b1, 4'd5,  32'hFFFF_FFFE, 4'd4,  32'h0000_0001, 1'b1, 1'b0}, // R6 clr bit0 zero
    {4'd6,  32'h0000_0000, 1'b1, 4'd5,  32'h0000_0001, 4'd4,  32'h0000_0000, 1'b0, 1'b0}, // R6 soft clear
    {4'd7,  32'h0000_0001, 1'b0, 4'd0,  32'h0000_0000, 4'd4,  32'h0000_0001, 1'b1, 1'b0}, // R7 hw line 0
    {4'd7,  32'h0000_0001, 1'b1, 4'd5,  32'h0000_0001, 4'd1,  32'h0000_0001, 1'b1, 1'b0}, // R7 hw survives clr
    {4'd8,  32'h0000_0000, 1'b1, 4'd0,  32'hFFFF_FFFF, 4'd2,  32'h0000_0021, 1'b0, 1'b0}, // R8 status wr
    {4'd8,  32'h0000_0000, 1'b1, 4'd9,  32'hFFFF_FFFF, 4'd10, 32'h0000_0100, 1'b0, 1'b0}, // R8 raw wr
    {4'd5,  32'h0000_0000, 1'b1, 4'd11, 32'h0000_0100, 4'd10, 32'h0000_0000, 1'b0, 1'b0}, // R5 fiq clear
    {4'd8,  32'h0000_0000, 1'b0, 4'd0,  32'h0000_0000, 4'd3,  32'h0000_0000, 1'b0, 1'b0}, // R8 clr reads 0
    {4'd3,  32'h8000_0000, 1'b1, 4'd10, 32'h8000_0000, 4'd9,  32'h8000_0000, 1'b0, 1'b1}, // R3 raw top bit
    {4'd8,  32'h8000_0000, 1'b0, 4'd0,  32'h0000_0000, 4'd11, 32'h0000_0000, 1'b0, 1'b1}, // R8 fiq clr read
    {4'd8,  32'h8000_0000, 1'b0, 4'd0,  32'h0000_0000, 4'd5,  32'h0000_0000, 1'b0, 1'b1}, // R8 soft clr read
    {4'd8,  32'h8000_0000, 1'b0, 4'd0,  32'h0000_0000, 4'd7,  32'h0000_0000, 1'b0, 1'b1}, // R8 unmapped
    {4'd1,  32'h8000_0000, 1'b1, 4'd2,  32'hFFFF_FFFF, 4'd0,  32'h8000_0000, 1'b1, 1'b1}, // R1 all enabled
    {4'd2,  32'h8000_0000, 1'b0, 4'd0,  32'h0000_0000, 4'd8,  32'h8000_0000, 1'b1, 1'b1}  // R2 fiq status top
  };

  task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic busWr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; busWdata = '0;
  endtask

  task automatic busRd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #2;
    d = busRdata;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    logic [31:0] rd;
    // R9: reset state, all sources high but masks clear
    srcLines = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(9, "irq after reset", 32'(irqOut), 32'd0);
    check(9, "fiq after reset", 32'(fiqOut), 32'd0);
    busRd(4'd2, rd);  check(9, "irq mask reset", rd, 32'h0);
    busRd(4'd10, rd); check(9, "fiq mask reset", rd, 32'h0);
    busRd(4'd1, rd);  check(3, "raw follows sources", rd, 32'hFFFF_FFFF);
    srcLines = '0;
    busRd(4'd4, rd);  check(9, "soft latch reset", rd, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [110:0] v;
      v = VEC[i];
      @(negedge clk);
      srcLines = v[106:75];
      if (v[74]) busWr(v[73:70], v[69:38]);
      busRd(v[37:34], rd);
      check(int'(v[110:107]), $sformatf("vec %0d rdata", i), rd, v[33:2]);
      check(int'(v[110:107]), $sformatf("vec %0d irq", i), 32'(irqOut), 32'(v[1]));
      check(int'(v[110:107]), $sformatf("vec %0d fiq", i), 32'(fiqOut), 32'(v[0]));
    end

    // R9: mid-run reset clears masks set above and the soft latch
    busWr(4'd4, 32'h1);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    srcLines = 32'h8000_0000;
    @(negedge clk);
    check(9, "irq after re-reset", 32'(irqOut), 32'd0);
    check(9, "fiq after re-reset", 32'(fiqOut), 32'd0);
    busRd(4'd1, rd); check(9, "soft cleared by reset", rd, 32'h8000_0000);

    // R10: fast set does not touch normal mask
    busWr(4'd10, 32'h8000_0000);
    busRd(4'd2, rd); check(10, "normal mask untouched", rd, 32'h0);
    check(2, "fiq from top line", 32'(fiqOut), 32'd1);
    check(1, "irq stays low", 32'(irqOut), 32'd0);

    done = 1'b1;
    finishRun();
  end
endmodule